// File: doc/BRIEF.md
# Overlapped Cache and Translation Lookup Unit

This unit serves one read-or-write lookup per cycle against a direct-mapped data cache and a small fully associative translation buffer, both consulted in the same cycle. The cache index comes from the page-offset part of the virtual address, so it needs no translated bits. Each cache line holds a physical page number as its tag. The lookup is a hit only if the translation buffer matches the virtual page and the selected line is valid with a tag equal to the translated page number.

Each accepted request yields exactly one registered outcome one cycle later. The outcome is one of: a hit with the data word; a memory request carrying the translated physical address; a translation miss, so that outside logic can walk the page table; or a protection fault for a write to a read-only page. Either fault freezes the unit until an acknowledge arrives. Separate ports fill the translation buffer, which uses a round-robin victim pointer, and write cache lines. A single invalidate input clears every valid bit in both structures.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, rsp_valid, every outcome flag, rsp_ref, rsp_dirty and fault_pend are 0, the translation buffer holds no valid entries, every cache line is invalid, and the fill pointer is at entry 0.
- R2: An accepted request is a hit when a valid translation entry matches req_va[31:12], and the cache line at index req_va[11:2] is valid with a tag equal to that entry's physical page. One cycle later rsp_valid and rsp_hit are 1, and rsp_data holds the line's word.
- R3: When the translation matches but the line is invalid or its tag differs, and there is no protection fault, rsp_mem_req is 1 one cycle later. rsp_pa is {physical page, req_va[11:0]}.
- R4: When no valid entry matches req_va[31:12], rsp_tlb_miss is 1 one cycle later, and fault_pend is set.
- R5: While fault_pend is 1, requests are dropped and give no response. A fault_ack while pending clears fault_pend at the next edge, and requests are accepted again from then on.
- R6: A write request (req_write=1) that matches an entry filled with tlb_wr_wperm=0 gives rsp_prot_fault=1 instead of a hit or memory request, and sets fault_pend.
- R7: On every translation match, the entry's referenced bit is set. rsp_ref reports the bit's value before the access: 0 on the first access after a fill, and 1 on later accesses.
- R8: A write that matches a writable entry sets its dirty bit. rsp_dirty reports the bit's value before the access. A read or a protection fault leaves the dirty bit unchanged.
- R9: A translation fill goes to the entry under the round-robin pointer and clears that entry's referenced and dirty bits. The pointer then advances modulo 16, so the 17th fill replaces the entry of the 1st fill.
- R10: inval_all clears every valid bit in both structures, and the fill pointer is left where it was. After inval_all, every lookup misses translation until the buffer is refilled, and every cache line reads as invalid until it is filled again.
- R11: Every response has exactly one of rsp_hit, rsp_mem_req, rsp_tlb_miss and rsp_prot_fault set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a write access |
| req_va | input | 32 | Virtual address |
| fault_ack | input | 1 | Clears a pending fault |
| inval_all | input | 1 | Clear all valid bits in both structures |
| tlb_wr_en | input | 1 | Write a translation entry at the round-robin pointer |
| tlb_wr_vpn | input | 20 | Virtual page number to store |
| tlb_wr_ppn | input | 20 | Physical page number to store |
| tlb_wr_wperm | input | 1 | Entry permits writes |
| cf_en | input | 1 | Cache line write |
| cf_idx | input | 10 | Line index |
| cf_tag | input | 20 | Physical tag for the line |
| cf_data | input | 32 | Data word for the line |
| cf_valid | input | 1 | Valid bit for the line |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Combined hit |
| rsp_mem_req | output | 1 | Memory access needed at rsp_pa |
| rsp_tlb_miss | output | 1 | Translation miss |
| rsp_prot_fault | output | 1 | Write to a read-only page |
| rsp_data | output | 32 | Data word on a hit, 0 otherwise |
| rsp_pa | output | 32 | Translated physical address |
| rsp_ref | output | 1 | Referenced bit of the entry before the access |
| rsp_dirty | output | 1 | Dirty bit of the entry before the access |
| fault_pend | output | 1 | A fault awaits acknowledge |

## Verification
The bench drives each request on a falling edge. The outcome flags, data, physical address and prior flag bits all register at the next rising edge. The bench therefore samples them at the falling edge that follows, one cycle after the request. fault_pend registers at the same edge as the faulting response, so it is checked in that same sample. A request made while a fault is pending is checked one cycle later for the absence of rsp_valid. The clear caused by fault_ack is checked one cycle after the acknowledge. Fills and invalidates act at the edge that captures them, so a lookup issued on a later cycle already sees their effect.

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int OFF_W  = 2,
  parameter int TLB_N  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [VA_W-1:0]             req_va,
  input  logic                        fault_ack,
  input  logic                        inval_all,
  input  logic                        tlb_wr_en,
  input  logic [VA_W-PAGE_W-1:0]      tlb_wr_vpn,
  input  logic [VA_W-PAGE_W-1:0]      tlb_wr_ppn,
  input  logic                        tlb_wr_wperm,
  input  logic                        cf_en,
  input  logic [PAGE_W-OFF_W-1:0]     cf_idx,
  input  logic [VA_W-PAGE_W-1:0]      cf_tag,
  input  logic [(8<<OFF_W)-1:0]       cf_data,
  input  logic                        cf_valid,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_mem_req,
  output logic                        rsp_tlb_miss,
  output logic                        rsp_prot_fault,
  output logic [(8<<OFF_W)-1:0]       rsp_data,
  output logic [VA_W-1:0]             rsp_pa,
  output logic                        rsp_ref,
  output logic                        rsp_dirty,
  output logic                        fault_pend
);
  localparam int PN_W  = VA_W - PAGE_W;
  localparam int IDX_W = PAGE_W - OFF_W;
  localparam int LINES = 1 << IDX_W;
  localparam int DW    = 8 << OFF_W;
  localparam int TW    = $clog2(TLB_N);

  logic [PN_W-1:0]  t_vpn [TLB_N];
  logic [PN_W-1:0]  t_ppn [TLB_N];
  logic [TLB_N-1:0] t_v, t_w, t_r, t_d;
  logic [TW-1:0]    ptr;

  logic [DW-1:0]    c_data [LINES];
  logic [PN_W-1:0]  c_tag  [LINES];
  logic [LINES-1:0] c_v;

  logic           thit;
  logic [TW-1:0]  hidx;
  always_comb begin
    thit = 1'b0;
    hidx = '0;
    for (int i = 0; i < TLB_N; i++)
      if (!thit && t_v[i] && t_vpn[i] == req_va[VA_W-1:PAGE_W]) begin
        thit = 1'b1;
        hidx = i[TW-1:0];
      end
  end

  wire [IDX_W-1:0] idx  = req_va[PAGE_W-1:OFF_W];
  wire [PN_W-1:0]  ppn  = t_ppn[hidx];
  wire             chit = c_v[idx] && c_tag[idx] == ppn;
  wire             prot = req_write && thit && !t_w[hidx];
  wire             acc  = req_valid && !fault_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_v <= '0; t_w <= '0; t_r <= '0; t_d <= '0; ptr <= '0;
    end else begin
      if (acc && thit) begin
        t_r[hidx] <= 1'b1;
        if (req_write && t_w[hidx]) t_d[hidx] <= 1'b1;
      end
      if (tlb_wr_en) begin
        t_vpn[ptr] <= tlb_wr_vpn;
        t_ppn[ptr] <= tlb_wr_ppn;
        t_w[ptr]   <= tlb_wr_wperm;
        t_v[ptr]   <= 1'b1;
        t_r[ptr]   <= 1'b0;
        t_d[ptr]   <= 1'b0;
        ptr        <= ptr + 1'b1;
      end
      if (inval_all) t_v <= '0;
    end
  end

  always_ff @(posedge clk)
    if (cf_en) begin
      c_data[cf_idx] <= cf_data;
      c_tag[cf_idx]  <= cf_tag;
    end

  always_ff @(posedge clk) begin
    if (!rst_n)          c_v <= '0;
    else if (inval_all)  c_v <= '0;
    else if (cf_en)      c_v[cf_idx] <= cf_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_mem_req <= 1'b0;
      rsp_tlb_miss <= 1'b0; rsp_prot_fault <= 1'b0;
      rsp_data <= '0; rsp_pa <= '0; rsp_ref <= 1'b0; rsp_dirty <= 1'b0;
      fault_pend <= 1'b0;
    end else begin
      rsp_valid      <= acc;
      rsp_hit        <= acc && thit && !prot && chit;
      rsp_mem_req    <= acc && thit && !prot && !chit;
      rsp_tlb_miss   <= acc && !thit;
      rsp_prot_fault <= acc && prot;
      rsp_data       <= (acc && thit && !prot && chit) ? c_data[idx] : '0;
      rsp_pa         <= thit ? {ppn, req_va[PAGE_W-1:0]} : '0;
      rsp_ref        <= acc && thit && t_r[hidx];
      rsp_dirty      <= acc && thit && t_d[hidx];
      fault_pend     <= (acc && (!thit || prot)) || (fault_pend && !fault_ack);
    end
  end
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_va,
  input logic            fault_ack,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_mem_req,
  input logic            rsp_tlb_miss,
  input logic            rsp_prot_fault,
  input logic [VA_W-1:0] rsp_pa,
  input logic            fault_pend
);
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_mem_req, rsp_tlb_miss, rsp_prot_fault}) == 1);

  p_drop_while_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pend |=> !rsp_valid);

  p_no_req_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_fault_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_tlb_miss || rsp_prot_fault)) |-> fault_pend);

  p_pa_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mem_req) |-> rsp_pa[PAGE_W-1:0] == $past(req_va[PAGE_W-1:0]));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pend && fault_ack) |=> !fault_pend);
endmodule

bind vipt_lookup vipt_lookup_chk #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/vipt_lookup_bench.sv
module vipt_lookup_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, fault_ack = 0, inval_all = 0;
  logic [31:0] req_va = 0;
  logic tlb_wr_en = 0, tlb_wr_wperm = 0;
  logic [19:0] tlb_wr_vpn = 0, tlb_wr_ppn = 0;
  logic cf_en = 0, cf_valid = 0;
  logic [9:0] cf_idx = 0;
  logic [19:0] cf_tag = 0;
  logic [31:0] cf_data = 0;
  logic rsp_valid, rsp_hit, rsp_mem_req, rsp_tlb_miss, rsp_prot_fault;
  logic [31:0] rsp_data, rsp_pa;
  logic rsp_ref, rsp_dirty, fault_pend;

  vipt_lookup u_vipt_lookup (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [19:0] m_vpn [16];
  logic [19:0] m_ppn [16];
  bit m_v [16], m_w [16], m_r [16], m_d [16];
  int ptr = 0;
  bit cache_live = 0;

  function automatic logic [31:0] cdat(int k);
    return 32'hC0DE0000 ^ (k * 32'h9E37);
  endfunction
  function automatic logic [19:0] ctag(int k);
    return 20'h200 + 20'(k & 15);
  endfunction
  function automatic bit cval(int k);
    return cache_live && (k % 7 != 0);
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic ack();
    @(negedge clk) fault_ack = 1;
    @(negedge clk) fault_ack = 0;
    chk("R5 ack clears", 64'(fault_pend), 64'd0);
  endtask

  task automatic tfill(input logic [19:0] v, input logic [19:0] p, input bit wp);
    @(negedge clk);
    tlb_wr_en = 1; tlb_wr_vpn = v; tlb_wr_ppn = p; tlb_wr_wperm = wp;
    @(negedge clk) tlb_wr_en = 0;
    m_vpn[ptr] = v; m_ppn[ptr] = p; m_w[ptr] = wp; m_v[ptr] = 1; m_r[ptr] = 0; m_d[ptr] = 0;
    ptr = (ptr + 1) % 16;
  endtask

  task automatic access(input bit w, input logic [31:0] va, input string r, input bit autoack);
    int e; bit th, ch, pf; logic [19:0] p; int k;
    e = -1;
    for (int i = 0; i < 16; i++) if (e < 0 && m_v[i] && m_vpn[i] == va[31:12]) e = i;
    th = (e >= 0);
    p  = th ? m_ppn[e] : 20'h0;
    k  = int'(va[11:2]);
    ch = cval(k) && ctag(k) == p;
    pf = th && w && !m_w[e];
    @(negedge clk) begin req_valid = 1; req_write = w; req_va = va; end
    @(negedge clk) req_valid = 0;
    chk({r, " outcome"}, 64'({rsp_valid, rsp_hit, rsp_mem_req, rsp_tlb_miss, rsp_prot_fault}),
        64'({1'b1, th && !pf && ch, th && !pf && !ch, !th, pf}));
    if (th) begin
      chk({r, " pa"}, 64'(rsp_pa), 64'({p, va[11:0]}));
      chk({r, " R7 ref"}, 64'(rsp_ref), 64'(m_r[e]));
      chk({r, " R8 dirty"}, 64'(rsp_dirty), 64'(m_d[e]));
      if (!pf && ch) chk({r, " R2 data"}, 64'(rsp_data), 64'(cdat(k)));
      m_r[e] = 1;
      if (w && !pf) m_d[e] = 1;
    end
    if (!th || pf) begin
      chk({r, " pend"}, 64'(fault_pend), 64'd1);
      if (autoack) ack();
    end
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_r[i] = 0; m_d[i] = 0; m_w[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset flags", 64'({rsp_valid, rsp_hit, rsp_mem_req, rsp_tlb_miss,
        rsp_prot_fault, rsp_ref, rsp_dirty, fault_pend}), 64'd0);
    rst_n = 1;
    access(0, 32'h0010_0004, "R1 empty tlb", 1);

    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      cf_en = 1; cf_idx = 10'(k); cf_tag = ctag(k); cf_data = cdat(k); cf_valid = (k % 7 != 0);
    end
    @(negedge clk) cf_en = 0;
    cache_live = 1;
    access(0, 32'h0010_0008, "R10 empty tlb after cache fill", 1);
    for (int i = 0; i < 16; i++) tfill(20'h100 + 20'(i), 20'h200 + 20'(i), (i % 2) == 0);

    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 64; j++) begin
        int k;
        k = j * 16 + ((j % 2 == 1) ? i : (i + 1) % 16);
        access(0, {20'h100 + 20'(i), 10'(k), 2'(j)}, "R2/R3 read sweep", 1);
      end

    for (int i = 0; i < 16; i++) access(1, {20'h100 + 20'(i), 10'(i), 2'b00}, "R6/R8 write", 1);
    for (int i = 0; i < 16; i++) access(0, {20'h100 + 20'(i), 10'(16 + i), 2'b00}, "R8 read after write", 1);
    for (int i = 0; i < 16; i += 2) access(1, {20'h100 + 20'(i), 10'(i), 2'b00}, "R8 second write", 1);

    access(0, 32'h0000_7010, "R4 tlb miss", 0);
    @(negedge clk) begin req_valid = 1; req_write = 0; req_va = 32'h0010_3004; end
    @(negedge clk) req_valid = 0;
    chk("R5 dropped while pending", 64'({rsp_valid, fault_pend}), 64'b01);
    ack();
    access(0, 32'h0010_3004, "R5 accepted after ack", 1);

    tfill(20'h300, 20'h2AB, 1);
    access(0, 32'h0010_0010, "R9 replaced entry misses", 1);
    access(0, 32'h0030_0044, "R9 new entry", 1);
    access(1, 32'h0030_0048, "R9 new entry write", 1);
    access(0, 32'h0010_1044, "R9 neighbour kept", 1);

    @(negedge clk) inval_all = 1;
    @(negedge clk) inval_all = 0;
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    cache_live = 0;
    access(0, 32'h0010_5014, "R10 tlb cleared", 1);
    access(0, 32'h0030_0044, "R10 tlb cleared new", 1);
    tfill(20'h105, 20'h205, 1);
    access(0, 32'h0010_5014, "R10 cache cleared", 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule